// File: doc/BRIEF.md
# Phase-Frequency Detector with Lock Monitor

This block compares two single-cycle comparison strobes, one from the divided reference and one from the divided feedback path, and turns their timing difference into pump-up and pump-down pulses for a charge pump. It is a synchronous design. Its clock is the undivided reference, so every pulse width is counted in reference periods. A configuration bit selects which output serves the leading strobe, which sets the detector slope. A second bit parks the pump in a high-impedance state.

Alongside the detector, a monitor measures every pump pulse against one reference period. A period is the interval that ends at a reference strobe. When 15 periods in a row have closed without a long pulse, the monitor raises a lock flag. A single long pulse drops the flag at once and restarts the count. The flag reaches the output pin only while lock reporting is enabled. Powering the block down clears the detector, the counter and the flag.

Top module: `pfd_lock`

## Requirements
- R1: While reset is applied, `pump_up`, `pump_dn` and `lock_det` are 0.
- R2: A reference strobe sets the internal up state and a feedback strobe sets the internal down state. The cycle after both states are high, both clear. Strobes that arrive while both are high are dropped. When the feedback strobe arrives k cycles after the reference strobe, the up pulse lasts k+1 cycles and the down pulse lasts 1 cycle. When the feedback strobe leads by k cycles, the two roles swap. The two pump outputs are never both high for two cycles in a row.
- R3: With `slope_pos`=0, `pump_up` carries the up state and `pump_dn` carries the down state. With `slope_pos`=1, the two are exchanged.
- R4: With `pump_off`=1, `pump_up` and `pump_dn` are 0 and `pump_hiz` is 1. Lock monitoring continues unchanged.
- R5: The lock flag sets on the reference strobe that closes the 15th consecutive clean period.
- R6: A pump pulse that stays high for more than 2 cycles, meaning the two strobes are at least 2 cycles apart, is long. A long pulse clears the lock flag and the count on the next edge, and the period that contains it does not count as clean. Strobes 0 or 1 cycle apart are short.
- R7: `lock_det` equals the lock flag while `ld_enable`=1 and is 0 otherwise. Clearing `ld_enable` does not disturb the stored flag.
- R8: With `pwr_en`=0, `pump_hiz` is 1, the pump outputs are 0, and the detector, the count and the lock flag are cleared on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Undivided reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Divided reference strobe, one cycle |
| fb_tick | input | 1 | Divided feedback strobe, one cycle |
| slope_pos | input | 1 | 1 selects positive detector slope |
| pump_off | input | 1 | 1 places the pump in high impedance |
| ld_enable | input | 1 | Enables the lock-detect output |
| pwr_en | input | 1 | 0 powers the block down |
| pump_up | output | 1 | Pump-up pulse |
| pump_dn | output | 1 | Pump-down pulse |
| pump_hiz | output | 1 | Pump high-impedance indication |
| lock_det | output | 1 | Lock-detect output |

## Verification
The bench sweeps every strobe offset from four cycles of feedback lead to four cycles of feedback lag under both slopes, and totals the pump pulse widths against the arithmetic k+1 and 1 widths. A design that counted the reset overlap wrongly, or that swapped the outputs under the wrong slope, shows up as a width mismatch. The threshold offsets of one and two cycles separate short pulses from long ones, which catches an off-by-one in the width limit. The lock count is checked at 14 and at 15 clean periods, both from a fresh start and after a long pulse. A design that counted the tainted period, or that failed to restart the count, would lock one period early. Powerdown, a disabled pump and a disabled lock output are each shown to hide or clear exactly the state they should, and nothing else.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pump_pair_t;
endpackage

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       ref_tick,
  input  logic       fb_tick,
  output pump_pair_t pulse
);
  pump_pair_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (!run) begin
      state_d = '0;
    end else if (state_q.up && state_q.dn) begin
      state_d = '0;
    end else begin
      if (ref_tick) state_d.up = 1'b1;
      if (fb_tick)  state_d.dn = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign pulse = state_q;

  // R2: overlap of up and down lasts a single cycle
  a_r2_overlap_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q.up && state_q.dn) |=> (!state_q.up && !state_q.dn));
endmodule

// File: rtl/pulse_width_mon.sv
module pulse_width_mon #(
  parameter int LONG_LIMIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic active,
  output logic long_now
);
  localparam int WCW = (LONG_LIMIT < 2) ? 1 : $clog2(LONG_LIMIT + 1);
  localparam logic [WCW-1:0] LIM = WCW'(LONG_LIMIT);

  logic [WCW-1:0] wcnt_q, wcnt_d;

  assign long_now = active && (wcnt_q == LIM);

  always_comb begin
    wcnt_d = wcnt_q;
    if (!run || !active)  wcnt_d = '0;
    else if (wcnt_q != LIM) wcnt_d = wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_d;
  end
endmodule

// File: rtl/lock_counter.sv
module lock_counter #(
  parameter int LOCK_PERIODS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic period_end,
  input  logic long_now,
  output logic locked
);
  localparam int CW = $clog2(LOCK_PERIODS + 1);
  localparam logic [CW-1:0] FULL = CW'(LOCK_PERIODS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          taint_q, taint_d;
  logic          lock_q, lock_d;

  always_comb begin
    cnt_d   = cnt_q;
    taint_d = taint_q;
    if (!run) begin
      cnt_d   = '0;
      taint_d = 1'b0;
    end else begin
      if (period_end) begin
        if (!taint_q && (cnt_q != FULL)) cnt_d = cnt_q + 1'b1;
        taint_d = 1'b0;
      end
      if (long_now) begin
        cnt_d   = '0;
        taint_d = 1'b1;
      end
    end
    lock_d = (cnt_d == FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      taint_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      taint_q <= taint_d;
      lock_q  <= lock_d;
    end
  end

  assign locked = lock_q;

  // R5: the flag can only rise on a period boundary
  a_r5_lock_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(period_end));
  // R6: a long pulse drops the flag on the next edge
  a_r6_long_clears: assert property (@(posedge clk) disable iff (!rst_n)
    long_now |=> !lock_q);
  // R8: powerdown empties the count and the flag
  a_r8_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0 && !lock_q));
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock
  import pfd_lock_pkg::*;
#(
  parameter int LONG_LIMIT   = 2,
  parameter int LOCK_PERIODS = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic fb_tick,
  input  logic slope_pos,
  input  logic pump_off,
  input  logic ld_enable,
  input  logic pwr_en,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_hiz,
  output logic lock_det
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  pump_pair_t det;
  logic       long_now;
  logic       locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pfd_core u_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (pwr_en),
    .ref_tick (ref_tick),
    .fb_tick  (fb_tick),
    .pulse    (det)
  );

  pulse_width_mon #(.LONG_LIMIT(LONG_LIMIT)) u_width (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (pwr_en),
    .active   (det.up | det.dn),
    .long_now (long_now)
  );

  lock_counter #(.LOCK_PERIODS(LOCK_PERIODS)) u_lock (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .run        (pwr_en),
    .period_end (ref_tick),
    .long_now   (long_now),
    .locked     (locked)
  );

  assign pump_hiz = pump_off | ~pwr_en;
  assign pump_up  = ~pump_hiz & (slope_pos ? det.dn : det.up);
  assign pump_dn  = ~pump_hiz & (slope_pos ? det.up : det.dn);
  assign lock_det = ld_enable & locked;

  // R4: a disabled pump emits no pulses
  a_r4_pump_off_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    pump_off |-> (pump_hiz && !pump_up && !pump_dn));
endmodule

// File: tb/sim_pfd_lock.sv
`timescale 1ns/1ps
module sim_pfd_lock;
  localparam int P = 12;

  logic clk = 1'b0;
  logic rst_n, ref_tick, fb_tick, slope_pos, pump_off, ld_enable, pwr_en;
  logic pump_up, pump_dn, pump_hiz, lock_det;

  int checks = 0;
  int errors = 0;
  int up_tot, dn_tot, dbl;
  logic prev_both;

  always #2 clk = ~clk;

  pfd_lock u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_tick(fb_tick),
    .slope_pos(slope_pos), .pump_off(pump_off), .ld_enable(ld_enable),
    .pwr_en(pwr_en), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_hiz(pump_hiz), .lock_det(lock_det)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample();
    if (pump_up) up_tot++;
    if (pump_dn) dn_tot++;
    if (pump_up && pump_dn) begin
      if (prev_both) dbl++;
      prev_both = 1'b1;
    end else begin
      prev_both = 1'b0;
    end
  endtask

  // one idle period, then n reference strobes P apart; feedback offset k
  task automatic run(input int n, input int k);
    up_tot = 0; dn_tot = 0; dbl = 0; prev_both = 1'b0;
    for (int c = 0; c < (n + 1) * P; c++) begin
      @(negedge clk);
      sample();
      ref_tick = (c >= P) && (c <= n * P) && (c % P == 0);
      fb_tick  = ((c - k) >= P) && ((c - k) <= n * P) && ((c - k) % P == 0);
    end
    @(negedge clk);
    sample();
    ref_tick = 1'b0;
    fb_tick  = 1'b0;
  endtask

  task automatic power_cycle();
    @(negedge clk); pwr_en = 1'b0;
    @(negedge clk);
    @(negedge clk); pwr_en = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; fb_tick = 1'b0; slope_pos = 1'b0;
    pump_off = 1'b0; ld_enable = 1'b1; pwr_en = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 up", int'(pump_up), 0);
    chk("R1 dn", int'(pump_dn), 0);
    chk("R1 lock", int'(lock_det), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // threshold from a fresh start
    run(14, 0);
    chk("R5 lock after 14", int'(lock_det), 0);
    chk("R2 up width k=0", up_tot, 14);
    chk("R2 dn width k=0", dn_tot, 14);
    run(1, 0);
    chk("R5 lock after 15", int'(lock_det), 1);

    // output gating keeps the flag
    @(negedge clk); ld_enable = 1'b0;
    @(negedge clk);
    chk("R7 gated off", int'(lock_det), 0);
    ld_enable = 1'b1;
    @(negedge clk);
    chk("R7 flag retained", int'(lock_det), 1);

    // one long pulse
    run(1, 3);
    chk("R6 long clears", int'(lock_det), 0);
    chk("R2 up width k=3", up_tot, 4);
    chk("R2 dn width k=3", dn_tot, 1);
    run(15, 0);
    chk("R6 tainted period not counted", int'(lock_det), 0);
    run(1, 0);
    chk("R6 relock", int'(lock_det), 1);
    run(20, 1);
    chk("R6 one-cycle offset is short", int'(lock_det), 1);

    // pump disabled
    pump_off = 1'b1;
    run(3, 2);
    chk("R4 up silent", up_tot, 0);
    chk("R4 dn silent", dn_tot, 0);
    chk("R4 hiz", int'(pump_hiz), 1);
    chk("R4 monitor sees long", int'(lock_det), 0);
    run(16, 0);
    chk("R4 monitor locks", int'(lock_det), 1);
    pump_off = 1'b0;

    // polarity
    slope_pos = 1'b1;
    run(4, 3);
    chk("R3 swapped up", up_tot, 4);
    chk("R3 swapped dn", dn_tot, 16);
    slope_pos = 1'b0;

    // powerdown
    run(16, 0);
    chk("R8 locked before pd", int'(lock_det), 1);
    @(negedge clk); pwr_en = 1'b0;
    @(negedge clk);
    chk("R8 lock cleared", int'(lock_det), 0);
    chk("R8 hiz", int'(pump_hiz), 1);
    pwr_en = 1'b1;
    run(14, 0);
    chk("R8 count cleared", int'(lock_det), 0);
    run(1, 0);
    chk("R8 relock", int'(lock_det), 1);

    // sweep of offsets and slopes
    for (int pol = 0; pol < 2; pol++) begin
      for (int k = -4; k <= 4; k++) begin
        int lead, eu, ed, el;
        slope_pos = pol[0];
        power_cycle();
        run(16, k);
        lead = (k < 0 ? -k : k) + 1;
        eu = (k >= 0) ? 16 * lead : 16;
        ed = (k >= 0) ? 16 : 16 * lead;
        if (pol == 1) begin
          int t;
          t = eu; eu = ed; ed = t;
        end
        el = (k >= -1 && k <= 1) ? 1 : 0;
        chk($sformatf("R2/R3 up pol%0d k%0d", pol, k), up_tot, eu);
        chk($sformatf("R2/R3 dn pol%0d k%0d", pol, k), dn_tot, ed);
        chk($sformatf("R2 overlap pol%0d k%0d", pol, k), dbl, 0);
        chk($sformatf("R5/R6 lock pol%0d k%0d", pol, k), int'(lock_det), el);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule